// File: doc/BRIEF.md
# PS/2 Keyboard Scancode Receiver

This block takes the two wires of a PS/2 keyboard link into a fast system clock domain and turns each byte the keyboard sends into a registered 8-bit code. The slow keyboard clock and its data line first pass through a flip-flop synchronizer. The block then finds each high-to-low step of the keyboard clock and takes one data bit at each of these steps. When a frame is complete and its framing and parity checks hold, the code is presented together with a valid strobe that lasts one system cycle.

Accepted codes also enter a short history that keeps the four most recent bytes. The history is packed into one word, with the newest byte in the lowest eight bits, so that a hex display can show the recent traffic directly. Release sequences such as `F0` followed by a scancode are not interpreted. Each byte is reported as an ordinary code.

Top module: `kbd_scan_rx`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it is released, `code_out` is 0, `code_vld_out` is 0 and every byte of `hist_out` is 0.
- R2: Data bits are captured only on a high-to-low transition of the synchronized keyboard clock. Low-to-high transitions and steady levels do not capture data.
- R3: A frame is sent in this order: a start bit of 0, eight data bits with the least significant bit first, a parity bit, and a stop bit of 1. A well-formed frame produces `code_out` equal to the data byte.
- R4: Parity is odd: over the eight data bits and the parity bit together, the number of ones must be odd. A frame that fails this check gives no strobe and leaves `code_out` and `hist_out` unchanged.
- R5: While the receiver waits for a frame, a falling clock edge with the data line at 1 is not taken as a start bit. The next well-formed frame is still decoded correctly.
- R6: A frame whose stop bit is 0 is discarded with no strobe. The receiver then returns to waiting, so the next frame decodes correctly.
- R7: `code_vld_out` is high for exactly one system cycle for each accepted byte, and never for two cycles in a row.
- R8: `code_out` changes only in a cycle where `code_vld_out` is high, and otherwise holds the last accepted code.
- R9: On each accepted byte, the new code enters `hist_out[7:0]`, each older byte moves eight bits up, and the byte in `hist_out[31:24]` is dropped. Without an accepted byte, `hist_out` holds its value.
- R10: The byte `F0` is accepted and reported like any other code, so a key press followed by its release shows up in the history as XY, F0, XY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_in | input | 1 | Keyboard clock line, asynchronous, idles high |
| kb_dat_in | input | 1 | Keyboard data line, asynchronous |
| code_out | output | 8 | Last accepted scancode |
| code_vld_out | output | 1 | One-cycle strobe for each accepted code |
| hist_out | output | 32 | Last four codes, newest in bits 7:0 |

## Verification
The bench uses the default parameters: two synchronizer stages, 8-bit codes and a history depth of four. With these values, the fifth accepted byte is enough to push the oldest entry out of the packed word. The keyboard clock is driven with a half-period of only 20 system cycles. This keeps each frame to a few hundred cycles, so the bench can run well-formed, bad-parity, bad-start and bad-stop frames back to back and observe how the receiver recovers after each one.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned HIST_LEN = 4;
  localparam int unsigned SYNC_LEN = 2;

  function automatic logic odd_ok(input logic [CODE_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/kbd_fall_det.sv
module kbd_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic fall_out
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= line_in;
  end

  assign fall_out = prev_q & ~line_in;
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int unsigned DATA_W = kbd_rx_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_in,
  input  logic              dat_in,
  output logic [DATA_W-1:0] code_out,
  output logic              vld_out
);
  localparam int unsigned FRAME_N = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_N);
  localparam logic [CNT_W-1:0] POS_PAR  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] POS_STOP = CNT_W'(DATA_W + 2);

  logic [CNT_W-1:0]  pos_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      code_out <= '0;
      vld_out  <= 1'b0;
    end else begin
      vld_out <= 1'b0;
      if (fall_in) begin
        if (pos_q == '0) begin
          if (!dat_in) pos_q <= CNT_W'(1);
        end else if (pos_q == POS_PAR) begin
          par_q <= dat_in;
          pos_q <= POS_STOP;
        end else if (pos_q == POS_STOP) begin
          pos_q <= '0;
          if (dat_in && kbd_rx_pkg::odd_ok(sh_q, par_q)) begin
            code_out <= sh_q;
            vld_out  <= 1'b1;
          end
        end else begin
          sh_q  <= {dat_in, sh_q[DATA_W-1:1]};
          pos_q <= pos_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kbd_history.sv
module kbd_history #(
  parameter int unsigned BYTE_W = kbd_rx_pkg::CODE_W,
  parameter int unsigned DEPTH  = kbd_rx_pkg::HIST_LEN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push_in,
  input  logic [BYTE_W-1:0]       byte_in,
  output logic [DEPTH*BYTE_W-1:0] packed_out
);
  logic [BYTE_W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst)          ent_q[0] <= '0;
    else if (push_in) ent_q[0] <= byte_in;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)          ent_q[i] <= '0;
      else if (push_in) ent_q[i] <= ent_q[i-1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pack
    assign packed_out[i*BYTE_W +: BYTE_W] = ent_q[i];
  end
endmodule

// File: rtl/kbd_scan_rx.sv
module kbd_scan_rx #(
  parameter int unsigned BYTE_W  = kbd_rx_pkg::CODE_W,
  parameter int unsigned DEPTH   = kbd_rx_pkg::HIST_LEN,
  parameter int unsigned SYNC_N  = kbd_rx_pkg::SYNC_LEN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    kb_clk_in,
  input  logic                    kb_dat_in,
  output logic [BYTE_W-1:0]       code_out,
  output logic                    code_vld_out,
  output logic [DEPTH*BYTE_W-1:0] hist_out
);
  logic [SYNC_N-1:0] clk_sync_q, dat_sync_q;
  logic              kb_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync_q <= '1;
      dat_sync_q <= '1;
    end else begin
      clk_sync_q[0] <= kb_clk_in;
      dat_sync_q[0] <= kb_dat_in;
    end
  end

  for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst) begin
        clk_sync_q[s] <= clk_sync_q[s-1];
        dat_sync_q[s] <= dat_sync_q[s-1];
      end
    end
  end

  kbd_fall_det u_fall (
    .clk      (clk),
    .rst      (rst),
    .line_in  (clk_sync_q[SYNC_N-1]),
    .fall_out (kb_fall)
  );

  kbd_frame_rx #(.DATA_W(BYTE_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .fall_in  (kb_fall),
    .dat_in   (dat_sync_q[SYNC_N-1]),
    .code_out (code_out),
    .vld_out  (code_vld_out)
  );

  kbd_history #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .push_in    (code_vld_out),
    .byte_in    (code_out),
    .packed_out (hist_out)
  );
endmodule

// File: rtl/kbd_scan_rx_chk.sv
module kbd_scan_rx_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [BYTE_W-1:0]       code_out,
  input logic                    code_vld_out,
  input logic [DEPTH*BYTE_W-1:0] hist_out
);
  localparam int unsigned HW = DEPTH * BYTE_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (code_out == '0 && !code_vld_out && hist_out == '0));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld_out |=> !code_vld_out);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_out) |-> code_vld_out);

  // R9
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    code_vld_out |=> (hist_out[BYTE_W-1:0] == $past(code_out) &&
                      hist_out[HW-1:BYTE_W] == $past(hist_out[HW-BYTE_W-1:0])));

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !code_vld_out |=> $stable(hist_out));
endmodule

bind kbd_scan_rx kbd_scan_rx_chk #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .code_out     (code_out),
  .code_vld_out (code_vld_out),
  .hist_out     (hist_out)
);

// File: tb/sim_kbd_scan_rx.sv
`timescale 1ns/1ps
module sim_kbd_scan_rx;
  localparam int HALF = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kb_clk = 1'b1;
  logic        kb_dat = 1'b1;
  logic [7:0]  code_out;
  logic        code_vld_out;
  logic [31:0] hist_out;

  int checks = 0, errors = 0;
  int pulses = 0, dbl = 0;
  logic [7:0]  last_code = 8'h00;
  logic [31:0] exp_hist = 32'h0;
  logic        prev_v = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  kbd_scan_rx u0 (
    .clk(clk), .rst(rst), .kb_clk_in(kb_clk), .kb_dat_in(kb_dat),
    .code_out(code_out), .code_vld_out(code_vld_out), .hist_out(hist_out)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (code_vld_out) begin
        pulses++;
        last_code = code_out;
        if (prev_v) dbl++;
      end
      prev_v = code_vld_out;
    end else prev_v = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bits[0] is sent first
  task automatic send_bits(input logic [10:0] bits);
    for (int i = 0; i < 11; i++) begin
      kb_dat = bits[i];
      wait_cyc(HALF);
      kb_clk = 1'b0;
      wait_cyc(HALF);
      kb_clk = 1'b1;
    end
    kb_dat = 1'b1;
    wait_cyc(8);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic par;
    par = ~(^d) ^ bad_par;
    send_bits({~bad_stop, par, d, 1'b0});
  endtask

  task automatic expect_accept(input logic [7:0] d, input int p0, input string req);
    exp_hist = {exp_hist[23:0], d};
    check(pulses == p0 + 1, req, pulses, p0 + 1);
    check(code_out == d, req, code_out, d);
    check(hist_out == exp_hist, "R9", hist_out, exp_hist);
  endtask

  task automatic t_reset();
    wait_cyc(1);
    check(code_out == 8'h0 && !code_vld_out, "R1", {code_vld_out, code_out}, 0);
    check(hist_out == 32'h0, "R1", hist_out, 0);
    @(negedge clk) rst = 1'b0;
    wait_cyc(1);
    check(code_out == 8'h0 && !code_vld_out && hist_out == 32'h0, "R1", hist_out, 0);
  endtask

  task automatic t_basic();
    int p0;
    p0 = pulses; send_frame(8'h1C, 0, 0); expect_accept(8'h1C, p0, "R3");
    p0 = pulses; send_frame(8'h81, 0, 0); expect_accept(8'h81, p0, "R3");
    p0 = pulses; send_frame(8'hFF, 0, 0); expect_accept(8'hFF, p0, "R3");
    p0 = pulses; send_frame(8'h00, 0, 0); expect_accept(8'h00, p0, "R2");
  endtask

  task automatic t_parity();
    int p0;
    p0 = pulses;
    send_frame(8'h5A, 1, 0);
    check(pulses == p0, "R4", pulses, p0);
    check(code_out == 8'h00, "R4", code_out, 8'h00);
    check(hist_out == exp_hist, "R4", hist_out, exp_hist);
    p0 = pulses; send_frame(8'h5A, 0, 0); expect_accept(8'h5A, p0, "R4");
  endtask

  task automatic t_bad_start();
    int p0;
    p0 = pulses;
    kb_dat = 1'b1;
    wait_cyc(HALF); kb_clk = 1'b0; wait_cyc(HALF); kb_clk = 1'b1; wait_cyc(HALF);
    check(pulses == p0, "R5", pulses, p0);
    send_frame(8'h33, 0, 0); expect_accept(8'h33, p0, "R5");
  endtask

  task automatic t_bad_stop();
    int p0;
    p0 = pulses;
    send_frame(8'h29, 0, 1);
    check(pulses == p0, "R6", pulses, p0);
    check(hist_out == exp_hist, "R6", hist_out, exp_hist);
    send_frame(8'h29, 0, 0); expect_accept(8'h29, p0, "R6");
  endtask

  task automatic t_release();
    int p0;
    p0 = pulses; send_frame(8'h1C, 0, 0); expect_accept(8'h1C, p0, "R10");
    p0 = pulses; send_frame(8'hF0, 0, 0); expect_accept(8'hF0, p0, "R10");
    p0 = pulses; send_frame(8'h1C, 0, 0); expect_accept(8'h1C, p0, "R10");
    check(hist_out[23:0] == 24'h1CF01C, "R10", hist_out[23:0], 24'h1CF01C);
  endtask

  task automatic t_overflow();
    int p0;
    logic [7:0] v [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    for (int i = 0; i < 5; i++) begin
      p0 = pulses; send_frame(v[i], 0, 0); expect_accept(v[i], p0, "R9");
    end
    check(hist_out == 32'h22334455, "R9", hist_out, 32'h22334455);
    wait_cyc(50);
    check(hist_out == 32'h22334455 && code_out == 8'h55, "R8", hist_out, 32'h22334455);
    check(dbl == 0, "R7", dbl, 0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    wait_cyc(5);
    t_basic();
    t_parity();
    t_bad_start();
    t_bad_stop();
    t_release();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule